// File: doc/BRIEF.md
# Serial Channel-Enable Register with Fault Status Capture

This block is the digital control core of a multi-channel constant-current sink driver. A controller sends one enable bit per channel over a serial data and serial clock pair. The bits collect in a shift register whose top bit is driven back out, so several devices can share one data path in a daisy chain. A latch strobe copies the shift register into the channel-enable latch. A blanking input turns every channel off while it is high. While it is low, each channel follows its latch bit.

The same strobe also reloads the shift register with a status word. The controller can then clock that word out on the serial output. The status word holds one fault bit per channel. A bit reports an open-circuit or grounded output, seen by a per-channel comparator input. A channel must have been driven on for a minimum qualifying time before its fault bit can be set. A thermal-warning input forces every status bit to 1. While blanking is low, the status latch tracks the live fault word. When blanking rises, the latch freezes and holds that value for readout.

The serial clock, serial data, strobe, blanking, thermal and comparator inputs are all sampled into one system clock domain. Edges are detected there. After power-up the registers have no guaranteed content, so blanking must be held high until valid enable data has been committed. An optional reset clears the registers, but that is a convenience and not part of the contract.

Top module: `ledsink_ctrl`

## Requirements
- R1: On each detected rising edge of the serial clock, the sampled serial data bit enters bit 0 and every other bit moves one place up. The serial output always shows bit 15, so the first bit shifted in appears there after 16 shifts.
- R2: On a detected rising edge of the latch strobe, the shift register contents are copied into the channel-enable latch. Bit n of the latch controls channel n.
- R3: On the same strobe edge, the shift register is loaded with the status latch. Status bit 15 appears first on the serial output, and the lower bits follow one per serial clock.
- R4: While blanking is high, all channel outputs are 0. This takes effect in the same cycle as the input, before any synchronisation. While blanking is low, channel n is 1 exactly when latch bit n is 1.
- R5: A live fault bit is 1 only when all of these hold: the channel is enabled, blanking is low, the channel is qualified, and its comparator input is 1. Otherwise the bit is 0.
- R6: A channel is qualified only after it has been driven on for QUAL_CYCLES consecutive system clocks. Any off cycle restarts the count.
- R7: While blanking is low, the status latch follows the live fault word. From the rising edge of blanking it holds its value, whatever the comparator and thermal inputs do.
- R8: While the thermal-warning input is high, every bit of the live fault word is 1.
- R9: A second strobe with no serial clock edge since the previous strobe commits the status word into the channel-enable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Optional asynchronous active-low reset |
| ser_in | input | 1 | Serial enable data |
| ser_clk | input | 1 | Serial shift clock, sampled |
| lat_stb | input | 1 | Commit strobe, rising edge active |
| blank | input | 1 | High forces all channels off and freezes status |
| therm_warn | input | 1 | Over-temperature warning flag |
| open_det | input | NCH | Per-channel low-output-voltage comparator results |
| ser_out | output | 1 | Serial output, top bit of shift register |
| chan_on | output | NCH | Per-channel sink drive enable |

## Verification
The hardest case to reach is the window in which a channel is enabled and faulty but not yet qualified. Blanking must rise before the qualifying count finishes, and the frozen status must then be read back through a strobe and sixteen serial clocks. The bench builds this case with a long qualifying parameter and a short blank-low window. It then repeats the setup with a long window and expects the opposite result. The double-strobe overwrite is reached from a thermal warning captured while blanking. Two strobes with no shift between them must put the all-ones status into the enable latch.

// File: rtl/ledsink_pkg.sv
package ledsink_pkg;
   typedef enum logic [1:0] {
      SR_HOLD   = 2'd0,
      SR_SHIFT  = 2'd1,
      SR_RELOAD = 2'd2
   } sr_op_e;
endpackage

// File: rtl/level_sync.sv
module level_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[i] <= '0;
            else         chain[i] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge arst_n) begin
            if (!arst_n) chain[i] <= '0;
            else         chain[i] <= chain[i-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/edge_sync.sv
module edge_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] rise
);
   logic [W-1:0] lvl;
   logic [W-1:0] prev;

   level_sync #(.W(W), .STAGES(STAGES)) u_sync (
      .clk(clk), .arst_n(arst_n), .d(d), .q(lvl)
   );

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) prev <= '0;
      else         prev <= lvl;
   end

   assign rise = lvl & ~prev;
endmodule

// File: rtl/shift_latch.sv
module shift_latch
   import ledsink_pkg::*;
#(
   parameter int NCH = 16
) (
   input  logic           clk,
   input  logic           arst_n,
   input  sr_op_e         op,
   input  logic           ser_bit,
   input  logic [NCH-1:0] status_word,
   output logic [NCH-1:0] shreg,
   output logic [NCH-1:0] en_q
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         shreg <= '0;
         en_q  <= '0;
      end else begin
         unique case (op)
            SR_SHIFT:  shreg <= {shreg[NCH-2:0], ser_bit};
            SR_RELOAD: begin
               en_q  <= shreg;
               shreg <= status_word;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/fault_capture.sv
module fault_capture #(
   parameter int NCH         = 16,
   parameter int QUAL_CYCLES = 8
) (
   input  logic           clk,
   input  logic           arst_n,
   input  logic [NCH-1:0] drive,
   input  logic [NCH-1:0] open_s,
   input  logic           therm_s,
   input  logic           blank_s,
   output logic [NCH-1:0] live,
   output logic [NCH-1:0] stat_q
);
   localparam int CW = $clog2(QUAL_CYCLES + 1);
   localparam logic [CW-1:0] QMAX = CW'(QUAL_CYCLES);

   logic [NCH-1:0] qual;
   logic [NCH-1:0] raw;

   for (genvar n = 0; n < NCH; n++) begin : g_ch
      logic [CW-1:0] cnt;
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)          cnt <= '0;
         else if (!drive[n])   cnt <= '0;
         else if (cnt != QMAX) cnt <= cnt + 1'b1;
      end
      assign qual[n] = (cnt == QMAX);
      assign raw[n]  = drive[n] & qual[n] & open_s[n];
   end

   assign live = therm_s ? '1 : raw;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)      stat_q <= '0;
      else if (!blank_s) stat_q <= live;
   end
endmodule

// File: rtl/ledsink_ctrl.sv
module ledsink_ctrl
   import ledsink_pkg::*;
#(
   parameter int NCH         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYCLES = 8,
   parameter bit HAS_RESET   = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_in,
   input  logic           ser_clk,
   input  logic           lat_stb,
   input  logic           blank,
   input  logic           therm_warn,
   input  logic [NCH-1:0] open_det,
   output logic           ser_out,
   output logic [NCH-1:0] chan_on
);
   if (NCH < 2 || SYNC_STAGES < 2 || QUAL_CYCLES < 1) begin : g_bad_cfg
      $error("ledsink_ctrl: NCH>=2, SYNC_STAGES>=2, QUAL_CYCLES>=1 required");
   end

   logic arst_n;
   if (HAS_RESET) begin : g_rst
      assign arst_n = rst_n;
   end else begin : g_norst
      assign arst_n = 1'b1;
   end

   logic [1:0]     edge_rise;
   logic [2:0]     lvl_s;
   logic [NCH-1:0] open_s;
   logic           sclk_rise, lat_rise, ser_d, blank_s, therm_s;
   sr_op_e         op;
   logic [NCH-1:0] shreg, en_q, stat_q, live, drive;

   edge_sync #(.W(2), .STAGES(SYNC_STAGES)) u_edges (
      .clk(clk), .arst_n(arst_n), .d({lat_stb, ser_clk}), .rise(edge_rise)
   );
   level_sync #(.W(3), .STAGES(SYNC_STAGES)) u_levels (
      .clk(clk), .arst_n(arst_n), .d({therm_warn, blank, ser_in}), .q(lvl_s)
   );
   level_sync #(.W(NCH), .STAGES(SYNC_STAGES)) u_open (
      .clk(clk), .arst_n(arst_n), .d(open_det), .q(open_s)
   );

   assign sclk_rise = edge_rise[0];
   assign lat_rise  = edge_rise[1];
   assign ser_d     = lvl_s[0];
   assign blank_s   = lvl_s[1];
   assign therm_s   = lvl_s[2];

   always_comb begin
      if (lat_rise)       op = SR_RELOAD;
      else if (sclk_rise) op = SR_SHIFT;
      else                op = SR_HOLD;
   end

   shift_latch #(.NCH(NCH)) u_sr (
      .clk(clk), .arst_n(arst_n), .op(op), .ser_bit(ser_d),
      .status_word(stat_q), .shreg(shreg), .en_q(en_q)
   );

   assign drive = en_q & {NCH{~blank_s}};

   fault_capture #(.NCH(NCH), .QUAL_CYCLES(QUAL_CYCLES)) u_fault (
      .clk(clk), .arst_n(arst_n), .drive(drive), .open_s(open_s),
      .therm_s(therm_s), .blank_s(blank_s), .live(live), .stat_q(stat_q)
   );

   assign ser_out = shreg[NCH-1];
   assign chan_on = en_q & {NCH{~(blank | blank_s)}};
endmodule

// File: rtl/ledsink_ctrl_chk.sv
module ledsink_ctrl_chk #(
   parameter int NCH = 16
) (
   input logic           clk,
   input logic           rst_n,
   input logic           blank,
   input logic           blank_s,
   input logic           therm_s,
   input logic           sclk_rise,
   input logic           lat_rise,
   input logic           ser_d,
   input logic [NCH-1:0] shreg,
   input logic [NCH-1:0] en_q,
   input logic [NCH-1:0] stat_q,
   input logic [NCH-1:0] chan_on
);
   p_blank_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> (chan_on == '0));

   p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
      lat_rise |=> (en_q == $past(shreg)));

   p_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
      lat_rise |=> (shreg == $past(stat_q)));

   p_shift_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_rise && !lat_rise) |=> (shreg == {$past(shreg[NCH-2:0]), $past(ser_d)}));

   p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
      blank_s |=> $stable(stat_q));

   p_thermal_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (therm_s && !blank_s) |=> (stat_q == '1));
endmodule

bind ledsink_ctrl ledsink_ctrl_chk #(.NCH(NCH)) u_chk (
   .clk(clk), .rst_n(arst_n), .blank(blank), .blank_s(blank_s),
   .therm_s(therm_s), .sclk_rise(sclk_rise), .lat_rise(lat_rise),
   .ser_d(ser_d), .shreg(shreg), .en_q(en_q), .stat_q(stat_q),
   .chan_on(chan_on)
);

// File: tb/sim_ledsink_ctrl.sv
module sim_ledsink_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NCH        = 16;
   localparam int QUAL       = 20;
   localparam int SETTLE     = 4;
   localparam int WDOG_LIMIT = 100000;

   logic clk = 1'b0;
   logic rst_n, ser_in, ser_clk, lat_stb, blank, therm_warn;
   logic [NCH-1:0] open_det;
   logic ser_out;
   logic [NCH-1:0] chan_on;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ledsink_ctrl #(.NCH(NCH), .SYNC_STAGES(2), .QUAL_CYCLES(QUAL), .HAS_RESET(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .ser_clk(ser_clk),
      .lat_stb(lat_stb), .blank(blank), .therm_warn(therm_warn),
      .open_det(open_det), .ser_out(ser_out), .chan_on(chan_on)
   );

   // {enable word, comparator word, thermal, expected status}
   localparam logic [48:0] VEC [6] = '{
      {16'hFFFF, 16'h0000, 1'b0, 16'h0000},
      {16'hA5A5, 16'hFFFF, 1'b0, 16'hA5A5},
      {16'h0F0F, 16'h3C3C, 1'b0, 16'h0C0C},
      {16'h0000, 16'hFFFF, 1'b0, 16'h0000},
      {16'h1234, 16'h0000, 1'b1, 16'hFFFF},
      {16'h8001, 16'h8000, 1'b0, 16'h8000}
   };

   task automatic tick(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(string tag, logic [NCH-1:0] act, logic [NCH-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic sclk_pulse();
      ser_clk = 1'b1; tick(SETTLE);
      ser_clk = 1'b0; tick(SETTLE);
   endtask

   task automatic strobe();
      lat_stb = 1'b1; tick(SETTLE);
      lat_stb = 1'b0; tick(SETTLE);
   endtask

   task automatic load_word(logic [NCH-1:0] w);
      for (int k = NCH-1; k >= 0; k--) begin
         ser_in = w[k];
         sclk_pulse();
      end
      ser_in = 1'b0;
   endtask

   task automatic read_word(output logic [NCH-1:0] w);
      ser_in = 1'b0;
      for (int k = 0; k < NCH; k++) begin
         w[NCH-1-k] = ser_out;
         sclk_pulse();
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   endtask

   initial begin
      for (int c = 0; c < WDOG_LIMIT; c++) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog act=%h exp=%h", 1'b1, 1'b0);
      finish_run();
   end

   initial begin
      logic [NCH-1:0] rd;
      rst_n = 1'b0; ser_in = 1'b0; ser_clk = 1'b0; lat_stb = 1'b0;
      blank = 1'b1; therm_warn = 1'b0; open_det = '0;
      tick(3);
      rst_n = 1'b1;
      tick(SETTLE);
      check("R4 blank high after start", chan_on, '0);

      // R1: shift register acts as a 16-deep serial delay
      load_word(16'hC3A1);
      read_word(rd);
      check("R1 serial pass-through", rd, 16'hC3A1);

      // Table walk: R2 commit, R4 gating, R5/R8 fault word, R7 freeze, R3 readout
      for (int v = 0; v < 6; v++) begin
         logic [NCH-1:0] w, o, e;
         logic t;
         {w, o, t, e} = VEC[v];
         load_word(w);
         strobe();
         blank = 1'b0; open_det = o; therm_warn = t;
         tick(QUAL + 40);
         check($sformatf("R2 commit vec%0d", v), chan_on, w);
         blank = 1'b1;
         #1;
         check($sformatf("R4 immediate off vec%0d", v), chan_on, '0);
         tick(SETTLE);
         open_det = ~o; therm_warn = 1'b0;   // R7: must not disturb frozen status
         tick(SETTLE);
         strobe();
         read_word(rd);
         check($sformatf("R3 R5 R7 R8 status vec%0d", v), rd, e);
         open_det = '0;
      end

      // R6: a short on-window does not qualify the fault
      load_word(16'hFFFF);
      strobe();
      open_det = 16'hFFFF;
      blank = 1'b0;
      tick(QUAL / 2);
      blank = 1'b1;
      tick(SETTLE);
      strobe();
      read_word(rd);
      check("R6 unqualified window", rd, 16'h0000);
      load_word(16'hFFFF);
      strobe();
      blank = 1'b0;
      tick(QUAL + 10);
      blank = 1'b1;
      tick(SETTLE);
      strobe();
      read_word(rd);
      check("R6 qualified window", rd, 16'hFFFF);
      open_det = '0;

      // R9: double strobe commits the captured thermal status
      therm_warn = 1'b1;
      blank = 1'b0;
      tick(SETTLE * 2);
      blank = 1'b1;
      tick(SETTLE);
      therm_warn = 1'b0;
      load_word(16'h00FF);
      strobe();
      strobe();
      check("R9 blanked after double strobe", chan_on, '0);
      blank = 1'b0;
      tick(SETTLE);
      check("R9 status overwrote enables", chan_on, 16'hFFFF);
      blank = 1'b1;
      tick(SETTLE);

      finish_run();
   end
endmodule